// File: doc/BRIEF.md
# Burst Data Sequencer With Interrupts

This block drives the beat-by-beat timing of DRAM read and write bursts on a memory controller's data path. A burst command carries a direction, a start column, a prefetch mode and a burst-length setting. The sequencer then steps through the beats. On each beat it gives a strobe, the beat's position in the burst, the column that beat addresses and a read-data-valid flag. On the final beat of a burst that ran to its end it raises a one-cycle done flag.

Two device modes are supported. In the 4n-prefetch mode the burst length is 4, 8 or 16. A newer command of the same direction may cut the running burst short, but only once a whole group of four beats has been moved. A burst-terminate request stops the burst at the same kind of boundary. In the 8n-prefetch mode every burst is 8 beats long, always runs to completion, and terminate requests are discarded. A command that cannot take effect at once is parked in a single holding slot and starts at the first moment the rules allow.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted and after it is released with no command, beat_stb_o, data_valid_o and burst_done_o are 0.
- R2: A command accepted while idle produces beats from the next cycle on, with beat_idx_o counting 0,1,2,... on consecutive cycles. In 4n mode bl_sel_i selects the length: 0 gives 4 beats, 1 gives 8, and 2 or 3 give 16.
- R3: beat_col_o for beat i keeps the start column's bits above the burst-length field. Its low log2(BL) bits are (start column + i) modulo BL, so the beats wrap inside the aligned block.
- R4: data_valid_o is 1 exactly on beats of a read burst (cmd_write_i = 0) and 0 on write beats and when idle.
- R5: burst_done_o pulses for one cycle on the beat with index BL-1 of a burst that was not cut short. A burst ended by an interrupt or a terminate gives no pulse.
- R6: In 4n mode a waiting command of the same direction as the running burst cuts it after the beat with index 3, 7 or 11 (4, 8 or 12 beats moved). The new burst shows index 0 on the next cycle, with no gap.
- R7: A command that arrives mid-burst waits for its start point. A same-direction command in 4n mode waits for the next 4-beat boundary. A command of the opposite direction, or any command in 8n mode, waits for the end of the burst and then starts on the next cycle with no gap.
- R8: Only one command can wait at a time. A command that arrives while one is already waiting is discarded.
- R9: In 8n mode every burst is 8 beats long whatever bl_sel_i is, and it is never cut short.
- R10: term_i during a 4n-mode burst ends it after the next beat with index 3, 7 or 11. In 8n mode, or while idle, term_i is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Burst command present this cycle |
| cmd_write_i | input | 1 | 1 = write burst, 0 = read burst |
| cmd_col_i | input | COL_W | Start column of the burst |
| mode_8n_i | input | 1 | 1 = 8n-prefetch mode, 0 = 4n-prefetch mode |
| bl_sel_i | input | 2 | Burst length in 4n mode: 0 = 4, 1 = 8, 2/3 = 16 |
| term_i | input | 1 | Burst-terminate request |
| beat_stb_o | output | 1 | A data beat occurs this cycle |
| beat_idx_o | output | 4 | Position of the beat within its burst |
| beat_col_o | output | COL_W | Column addressed by this beat |
| data_valid_o | output | 1 | This beat carries read data |
| burst_done_o | output | 1 | Last beat of a burst that was not cut short |

## Verification
The bench goes after the cut points: a BL16 burst is interrupted once after 8 beats and once after 12. A design that cut at once, or at the wrong multiple of four, would return a beat-0 entry early or late and break the expected beat sequence. Opposite-direction and 8n-mode commands are issued mid-burst to catch a sequencer that interrupts when it must wait. A second command is sent while the slot is full, and a design that queued it would produce unexpected beats. Terminate is sent in both modes, checking that a 4n burst stops without a done pulse while an 8n burst runs all 8 beats. The start columns are unaligned, so a design without the wrap rule would put out wrong beat columns.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int IDX_W = 4;  // longest burst is 16 beats

  localparam logic [1:0] BL_SEL_4 = 2'd0;
  localparam logic [1:0] BL_SEL_8 = 2'd1;

  typedef struct packed {
    logic       wr;
    logic       mode8;
    logic [1:0] bl;
  } cmd_t;

  // last beat index of a burst
  function automatic logic [IDX_W-1:0] burst_lim(input logic m8, input logic [1:0] sel);
    if (m8 || sel == BL_SEL_8) return IDX_W'(7);
    if (sel == BL_SEL_4)       return IDX_W'(3);
    return IDX_W'(15);
  endfunction
endpackage

// File: rtl/bsq_cmd_hold.sv
module bsq_cmd_hold
  import bsq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_v_i,
  input  cmd_t             in_cmd_i,
  input  logic [COL_W-1:0] in_col_i,
  input  logic             take_i,
  output logic             cand_v_o,
  output cmd_t             cand_cmd_o,
  output logic [COL_W-1:0] cand_col_o
);
  logic             held_v_q;
  cmd_t             held_cmd_q;
  logic [COL_W-1:0] held_col_q;

  assign cand_v_o   = held_v_q | in_v_i;
  assign cand_cmd_o = held_v_q ? held_cmd_q : in_cmd_i;
  assign cand_col_o = held_v_q ? held_col_q : in_col_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_v_q   <= 1'b0;
      held_cmd_q <= '0;
      held_col_q <= '0;
    end else if (take_i) begin
      // held entry consumed; a fresh input refills the slot
      held_v_q <= held_v_q & in_v_i;
      if (held_v_q && in_v_i) begin
        held_cmd_q <= in_cmd_i;
        held_col_q <= in_col_i;
      end
    end else if (!held_v_q && in_v_i) begin
      held_v_q   <= 1'b1;
      held_cmd_q <= in_cmd_i;
      held_col_q <= in_col_i;
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_v_q && !take_i) |=> (held_v_q && $stable(held_col_q) && $stable(held_cmd_q)));
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import bsq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [IDX_W-1:0] lim_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] lim_o,
  output logic             last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      idx_o    <= '0;
      lim_o    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      idx_o    <= '0;
      lim_o    <= lim_i;
    end else if (stop_i) begin
      active_o <= 1'b0;
      idx_o    <= '0;
    end else if (active_o) begin
      idx_o <= idx_o + 1'b1;
    end
  end

  assign last_o = active_o && (idx_o == lim_o);

  assert_idx_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (idx_o <= lim_o));
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import bsq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_write_i,
  input  logic [COL_W-1:0] cmd_col_i,
  input  logic             mode_8n_i,
  input  logic [1:0]       bl_sel_i,
  input  logic             term_i,
  output logic             beat_stb_o,
  output logic [IDX_W-1:0] beat_idx_o,
  output logic [COL_W-1:0] beat_col_o,
  output logic             data_valid_o,
  output logic             burst_done_o
);
  localparam int PAD_W = COL_W - IDX_W;

  cmd_t             in_cmd, cand_cmd;
  logic             cand_v;
  logic [COL_W-1:0] cand_col;
  logic             start, stop, bound, term_eff;
  logic             active, at_last;
  logic [IDX_W-1:0] idx, lim;
  logic             cur_wr_q, cur_m8_q, term_pend_q;
  logic [COL_W-1:0] cur_col_q, mask, col_sum;

  assign in_cmd = '{wr: cmd_write_i, mode8: mode_8n_i, bl: bl_sel_i};

  bsq_cmd_hold #(.COL_W(COL_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_v_i     (cmd_valid_i),
    .in_cmd_i   (in_cmd),
    .in_col_i   (cmd_col_i),
    .take_i     (start),
    .cand_v_o   (cand_v),
    .cand_cmd_o (cand_cmd),
    .cand_col_o (cand_col)
  );

  bsq_beat_ctr u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .stop_i   (stop),
    .lim_i    (burst_lim(cand_cmd.mode8, cand_cmd.bl)),
    .active_o (active),
    .idx_o    (idx),
    .lim_o    (lim),
    .last_o   (at_last)
  );

  // cut point: 4 beats moved since last boundary, 4n mode, not the final beat
  assign bound    = active && !cur_m8_q && (idx[1:0] == 2'b11) && !at_last;
  assign term_eff = term_pend_q || (term_i && active && !cur_m8_q);
  assign start    = cand_v && (!active || at_last || (bound && (cand_cmd.wr == cur_wr_q)));
  assign stop     = active && !start && (at_last || (bound && term_eff));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_wr_q    <= 1'b0;
      cur_m8_q    <= 1'b0;
      cur_col_q   <= '0;
      term_pend_q <= 1'b0;
    end else begin
      if (start) begin
        cur_wr_q  <= cand_cmd.wr;
        cur_m8_q  <= cand_cmd.mode8;
        cur_col_q <= cand_col;
      end
      if (start || stop) term_pend_q <= 1'b0;
      else if (term_eff) term_pend_q <= 1'b1;
    end
  end

  assign mask    = {{PAD_W{1'b0}}, lim};
  assign col_sum = cur_col_q + {{PAD_W{1'b0}}, idx};

  assign beat_stb_o   = active;
  assign beat_idx_o   = idx;
  assign beat_col_o   = (cur_col_q & ~mask) | (col_sum & mask);
  assign data_valid_o = active && !cur_wr_q;
  assign burst_done_o = at_last;

  // a restart without a done pulse must follow a 4n boundary beat
  assert_cut_on_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_stb_o && beat_idx_o == '0 && $past(beat_stb_o) && !$past(burst_done_o))
      |-> ($past(beat_idx_o[1:0]) == 2'b11 && !$past(cur_m8_q)));

  assert_cut_same_dir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_stb_o && beat_idx_o == '0 && $past(beat_stb_o) && !$past(burst_done_o))
      |-> (cur_wr_q == $past(cur_wr_q)));

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |=> !burst_done_o);

  assert_rd_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> beat_stb_o);

  assert_fixed_len_8n_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_stb_o && cur_m8_q) |-> (lim == IDX_W'(7)));
endmodule

// File: tb/tb_burst_seq.sv
`timescale 1ns/1ps
module tb_burst_seq;
  localparam int COL_W = 10;

  typedef struct {
    int    idx;
    int    col;
    bit    rd;
    bit    done;
    string req;
  } beat_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic             cmd_write_i = 1'b0;
  logic [COL_W-1:0] cmd_col_i = '0;
  logic             mode_8n_i = 1'b0;
  logic [1:0]       bl_sel_i = 2'd0;
  logic             term_i = 1'b0;
  logic             beat_stb_o;
  logic [3:0]       beat_idx_o;
  logic [COL_W-1:0] beat_col_o;
  logic             data_valid_o;
  logic             burst_done_o;

  int    errors = 0;
  int    checks = 0;
  bit    ended = 1'b0;
  beat_t exp_q[$];

  always #4 clk_i = ~clk_i;

  burst_seq #(.COL_W(COL_W)) dut (.*);

  function automatic int exp_col(int col, int bl, int i);
    return (col & ~(bl - 1)) | ((col + i) & (bl - 1));
  endfunction

  task automatic push_burst(bit wr, int col, int bl, int count, string req);
    for (int i = 0; i < count; i++) begin
      beat_t b;
      b.idx  = i;
      b.col  = exp_col(col, bl, i);
      b.rd   = !wr;
      b.done = (count == bl) && (i == bl - 1);
      b.req  = req;
      exp_q.push_back(b);
    end
  endtask

  task automatic issue(bit wr, int col, bit m8, logic [1:0] bl);
    cmd_valid_i = 1'b1;
    cmd_write_i = wr;
    cmd_col_i   = COL_W'(col);
    mode_8n_i   = m8;
    bl_sel_i    = bl;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic pulse_term();
    term_i = 1'b1;
    @(negedge clk_i);
    term_i = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check_idle(string req);
    checks++;
    if (beat_stb_o !== 1'b0 || data_valid_o !== 1'b0 || burst_done_o !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: stb=%b valid=%b done=%b expected 0 0 0",
               req, beat_stb_o, data_valid_o, burst_done_o);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !ended && beat_stb_o === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected beat idx=%0d col=%0h, expected none", beat_idx_o, beat_col_o);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        if (int'(beat_idx_o) != e.idx || int'(beat_col_o) != e.col ||
            data_valid_o !== e.rd || burst_done_o !== e.done) begin
          errors++;
          $display("FAIL %s beat: idx=%0d col=%0h valid=%b done=%b expected idx=%0d col=%0h valid=%b done=%b",
                   e.req, beat_idx_o, beat_col_o, data_valid_o, burst_done_o,
                   e.idx, e.col, e.rd, e.done);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired, expected run to complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    check_idle("R1 in reset");
    rst_ni = 1'b1;
    wait_cyc(2);
    check_idle("R1 after reset");

    // R2 R3 R4: 4n BL4 read, unaligned column wraps
    push_burst(1'b0, 'h5, 4, 4, "R2 R3 R4 R5 bl4 read");
    issue(1'b0, 'h5, 1'b0, 2'd0);
    wait_cyc(10);
    check_idle("R2 bl4 ended");

    // R6: BL8 write cut after 4 beats by a same-direction write
    push_burst(1'b1, 'h12, 8, 4, "R6 bl8 cut at 4");
    push_burst(1'b1, 'h2B, 8, 8, "R6 R7 new burst after cut");
    issue(1'b1, 'h12, 1'b0, 2'd1);
    wait_cyc(1);
    issue(1'b1, 'h2B, 1'b0, 2'd1);
    wait_cyc(20);

    // R6 R7: BL16 cut after 8, then after 12
    push_burst(1'b0, 'h103, 16, 8, "R6 bl16 cut at 8");
    push_burst(1'b0, 'h21, 16, 12, "R6 bl16 cut at 12");
    push_burst(1'b0, 'h3E, 16, 16, "R2 R5 bl16 full");
    issue(1'b0, 'h103, 1'b0, 2'd2);
    wait_cyc(5);
    issue(1'b0, 'h21, 1'b0, 2'd3);
    wait_cyc(11);
    issue(1'b0, 'h3E, 1'b0, 2'd2);
    wait_cyc(30);
    check_idle("R5 after bl16");

    // R7: opposite direction waits for end of burst
    push_burst(1'b0, 'h44, 8, 8, "R7 read not cut by write");
    push_burst(1'b1, 'h56, 4, 4, "R7 write after read");
    issue(1'b0, 'h44, 1'b0, 2'd1);
    wait_cyc(1);
    issue(1'b1, 'h56, 1'b0, 2'd0);
    wait_cyc(20);

    // R9: 8n ignores bl_sel, never cut
    push_burst(1'b0, 'h7A, 8, 8, "R9 8n fixed length");
    push_burst(1'b0, 'h81, 8, 8, "R9 R7 8n second burst");
    issue(1'b0, 'h7A, 1'b1, 2'd0);
    wait_cyc(1);
    issue(1'b0, 'h81, 1'b1, 2'd2);
    wait_cyc(22);
    check_idle("R9 after 8n");

    // R10: terminate ignored in 8n
    push_burst(1'b1, 'h90, 8, 8, "R10 8n terminate ignored");
    issue(1'b1, 'h90, 1'b1, 2'd1);
    wait_cyc(1);
    pulse_term();
    wait_cyc(12);

    // R10: terminate in 4n stops at boundary without done
    push_burst(1'b1, 'hA5, 16, 4, "R10 4n terminate");
    issue(1'b1, 'hA5, 1'b0, 2'd2);
    wait_cyc(1);
    pulse_term();
    wait_cyc(2);
    check_idle("R10 stopped after 4 beats");
    wait_cyc(5);
    check_idle("R10 stays idle");
    pulse_term();
    wait_cyc(3);
    check_idle("R10 idle terminate ignored");

    // R8: second waiting command is discarded
    push_burst(1'b0, 'h0, 8, 4, "R8 first burst cut");
    push_burst(1'b0, 'h20, 8, 8, "R8 held command runs");
    issue(1'b0, 'h0, 1'b0, 2'd1);
    wait_cyc(1);
    issue(1'b0, 'h20, 1'b0, 2'd1);
    issue(1'b0, 'h40, 1'b0, 2'd1);
    wait_cyc(20);
    check_idle("R8 extra command dropped");

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing beats: %0d left, expected 0", exp_q.size());
    end

    ended = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule